// File: doc/BRIEF.md
# Configurable Serial Frame Transceiver

This block is a full-duplex serial transmitter and receiver. A six-bit frame configuration input sets the character format: the bench and the system above it choose between start/stop framing and a clock-synchronous shift mode, 7- or 8-bit characters, an optional parity bit of either sense, one or two stop bits, and a multiprocessor format. In that last format a flag bit takes the place of the parity bit.

Bit timing comes from an oversample enable input, `os_tick`. One bit lasts `OSR` (16) ticks. The transmitter accepts a byte through a valid/ready handshake and shifts it out least significant bit first on `txd`. The receiver finds a start bit on a falling edge of `rxd`, confirms it at the middle of the bit and samples every later bit at its middle. Each received character comes out with a one-cycle `rx_valid` pulse, together with its parity and framing flags.

In synchronous mode the transmitter also drives `sclk`, which idles high. It shifts eight bits. `txd` changes as `sclk` falls, and `rxd` is taken as `sclk` rises, so one character is received for every character sent.

Top module: `serframe_xcvr`

## Requirements
- R1: `frame_cfg` bit positions are [0] synchronous mode, [1] 7-bit characters, [2] parity enable, [3] odd parity, [4] two stop bits, [5] multiprocessor format. With [0]=0, an accepted byte goes out as a low start bit, then the data bits LSB first, then high stop bits. Each bit lasts OSR ticks, and `txd` is high whenever the transmitter is idle.
- R2: With [1]=1 in asynchronous mode, only data bits 0..6 are sent and bit 7 of `tx_data` is never sent. The receiver returns such a character with `rx_data[7]`=0.
- R3: With [2]=1 and [5]=0 in asynchronous mode, a parity bit follows the data. It makes the count of ones over data and parity even when [3]=0 and odd when [3]=1.
- R4: [4]=0 sends one high stop bit and [4]=1 sends two.
- R5: With [5]=1, [2] and [3] have no effect. The bit after the data is `tx_mpb`, and the receiver reports that bit on `rx_mpb` and never raises `rx_perr`.
- R6: `tx_ready` is high when idle. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the last bit of the frame has completed.
- R7: The receiver rebuilds each asynchronous character and presents `rx_data` with a one-cycle `rx_valid` pulse.
- R8: `rx_perr` is raised with `rx_valid` when parity is enabled and the received parity bit does not match the selected sense.
- R9: `rx_ferr` is raised with `rx_valid` when the first stop bit samples low. A second stop bit is not checked: a low level there starts the next frame.
- R10: With [0]=1, `sclk` idles high. The transmitter sends exactly 8 data bits with no start, stop or parity bit, and ignores [1]. Each bit starts with `sclk` falling, and `sclk` rises half a bit later.
- R11: In synchronous mode `rxd` is sampled at each rising `sclk`. After the eighth bit all 8 bits are presented with `rx_valid`, and `rx_perr` and `rx_ferr` stay low.
- R12: A low pulse on `rxd` that is gone by the middle of the start bit (8th tick) is discarded, and no character is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_cfg | input | 6 | Frame format selection (see R1) |
| os_tick | input | 1 | Oversample enable, OSR ticks per bit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_mpb | input | 1 | Multiprocessor flag bit to send |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| txd | output | 1 | Serial data out |
| sclk | output | 1 | Serial clock out (synchronous mode) |
| rxd | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle pulse: received character ready |
| rx_data | output | 8 | Received character |
| rx_mpb | output | 1 | Received multiprocessor flag bit |
| rx_perr | output | 1 | Parity error with this character |
| rx_ferr | output | 1 | Framing error with this character |

## Verification
With `os_tick` high every cycle, bit k of a frame is on `txd` from 16k to 16k+15 cycles after the accepting edge. The bench reads each bit 8 cycles into its slot, and in synchronous mode it reads `sclk` 4 cycles (low) and 12 cycles (high) into each slot. `tx_ready` returns 16·n cycles after acceptance, where n is the frame's bit count. The bench checks it half a cycle later, having seen it low during the last bit. Received characters appear about three cycles after the middle of the first stop bit, or 121 cycles after acceptance in synchronous mode. A negedge monitor records every pulse, and the bench compares the record only once the frame is over, so latency within a bit never decides a result.

// File: rtl/serframe_pkg.sv
package serframe_pkg;

  // bit 0 = sync ... bit 5 = mp (first field is the MSB)
  typedef struct packed {
    logic mp;
    logic two_stop;
    logic par_odd;
    logic par_en;
    logic seven;
    logic sync;
  } frame_cfg_t;

  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/serframe_sync.sv
module serframe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serframe_tx.sv
module serframe_tx
  import serframe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_cfg_t        cfg,
  input  logic              os_tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_mpb,
  output logic              tx_ready,
  output logic              txd,
  output logic              sclk,
  output logic              smp_stb
);
  localparam int TW      = $clog2(OSR);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CW      = $clog2(FRAME_W + 1);
  localparam int HALF    = OSR / 2 - 1;

  logic [FRAME_W-1:0] frame_c, shreg;
  logic [CW-1:0]      nbits_c, nbits_q, bit_q;
  logic [TW-1:0]      tick_q;
  logic [DATA_W-1:0]  dmask;
  logic               busy, sync_q, xbit, has_x;
  int                 nd;

  // frame image, bit 0 leaves first
  always_comb begin
    dmask = tx_data;
    if (cfg.seven) dmask[DATA_W-1] = 1'b0;
    xbit    = cfg.mp ? tx_mpb : ((^dmask) ^ cfg.par_odd);
    has_x   = cfg.mp || cfg.par_en;
    nd      = cfg.seven ? DATA_W - 1 : DATA_W;
    frame_c = '1;
    if (cfg.sync) begin
      frame_c[DATA_W-1:0] = tx_data;
      nbits_c = CW'(DATA_W);
    end else begin
      frame_c[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (i < nd) frame_c[1+i] = tx_data[i];
      if (has_x) frame_c[1+nd] = xbit;
      nbits_c = CW'(2 + nd + int'(has_x) + int'(cfg.two_stop));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      txd     <= 1'b1;
      sclk    <= 1'b1;
      smp_stb <= 1'b0;
      shreg   <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
      nbits_q <= '0;
      sync_q  <= 1'b0;
    end else begin
      smp_stb <= 1'b0;
      if (!busy) begin
        if (tx_valid) begin
          busy    <= 1'b1;
          txd     <= frame_c[0];
          shreg   <= {1'b1, frame_c[FRAME_W-1:1]};
          tick_q  <= '0;
          bit_q   <= '0;
          nbits_q <= nbits_c;
          sync_q  <= cfg.sync;
          if (cfg.sync) sclk <= 1'b0;
        end
      end else if (os_tick) begin
        if (tick_q == TW'(OSR - 1)) begin
          tick_q <= '0;
          if (bit_q == nbits_q - CW'(1)) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            sclk <= 1'b1;
          end else begin
            bit_q <= bit_q + CW'(1);
            txd   <= shreg[0];
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            if (sync_q) sclk <= 1'b0;
          end
        end else begin
          tick_q <= tick_q + TW'(1);
          if (sync_q && tick_q == TW'(HALF)) begin
            sclk    <= 1'b1;
            smp_stb <= 1'b1;
          end
        end
      end
    end
  end

  assign tx_ready = !busy;
endmodule

// File: rtl/serframe_rx.sv
module serframe_rx
  import serframe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_mode,
  input  logic              seven,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              smp_stb,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_perr,
  output logic              rx_ferr
);
  localparam int TW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_W + 2);
  localparam int HALF = OSR / 2 - 1;

  rx_state_e         st;
  logic              rx_s, prev, xbit, has_x;
  logic [TW-1:0]     tick;
  logic [IW-1:0]     idx, nd;
  logic [DATA_W-1:0] sh;

  serframe_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
  );

  always_comb begin
    nd    = seven ? IW'(DATA_W - 1) : IW'(DATA_W);
    has_x = mp || par_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      prev     <= 1'b1;
      tick     <= '0;
      idx      <= '0;
      sh       <= '0;
      xbit     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_mpb   <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      if (sync_mode) begin
        st   <= RX_IDLE;
        prev <= 1'b1;
        if (smp_stb) begin
          sh <= {rx_s, sh[DATA_W-1:1]};
          if (idx == IW'(DATA_W - 1)) begin
            idx      <= '0;
            rx_valid <= 1'b1;
            rx_data  <= {rx_s, sh[DATA_W-1:1]};
            rx_mpb   <= 1'b0;
          end else begin
            idx <= idx + IW'(1);
          end
        end
      end else if (os_tick) begin
        prev <= rx_s;
        case (st)
          RX_IDLE: begin
            if (prev && !rx_s) begin
              st   <= RX_START;
              tick <= '0;
            end
          end
          RX_START: begin
            if (tick == TW'(HALF)) begin
              tick <= '0;
              if (rx_s) begin
                st <= RX_IDLE;
              end else begin
                st  <= RX_BITS;
                idx <= '0;
                sh  <= '0;
              end
            end else begin
              tick <= tick + TW'(1);
            end
          end
          RX_BITS: begin
            if (tick == TW'(OSR - 1)) begin
              tick <= '0;
              if (idx < nd) begin
                sh  <= {rx_s, sh[DATA_W-1:1]};
                idx <= idx + IW'(1);
              end else if (has_x && idx == nd) begin
                xbit <= rx_s;
                idx  <= idx + IW'(1);
              end else begin
                st       <= RX_IDLE;
                idx      <= '0;
                rx_valid <= 1'b1;
                rx_ferr  <= !rx_s;
                rx_data  <= seven ? (sh >> 1) : sh;
                rx_mpb   <= mp ? xbit : 1'b0;
                rx_perr  <= par_en && !mp && (xbit != ((^sh) ^ par_odd));
              end
            end else begin
              tick <= tick + TW'(1);
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serframe_xcvr.sv
module serframe_xcvr
  import serframe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  frame_cfg,
  input  logic              os_tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_mpb,
  output logic              tx_ready,
  output logic              txd,
  output logic              sclk,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_perr,
  output logic              rx_ferr
);
  frame_cfg_t cfg;
  logic       smp_stb;

  assign cfg = frame_cfg_t'(frame_cfg);

  serframe_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .cfg(cfg), .os_tick(os_tick),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_mpb(tx_mpb),
    .tx_ready(tx_ready), .txd(txd), .sclk(sclk), .smp_stb(smp_stb)
  );

  serframe_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .sync_mode(cfg.sync), .seven(cfg.seven),
    .par_en(cfg.par_en), .par_odd(cfg.par_odd), .mp(cfg.mp),
    .os_tick(os_tick), .rxd(rxd), .smp_stb(smp_stb),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );
endmodule

// File: rtl/serframe_chk.sv
module serframe_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] frame_cfg,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       sclk,
  input logic       rx_valid,
  input logic       rx_perr,
  input logic       rx_ferr
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd); // R1
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !frame_cfg[0]) |=> !txd); // R1
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready); // R6
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> sclk); // R10
  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7
  AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    (rx_perr || rx_ferr) |-> rx_valid); // R8
  AST_MP_NO_PERR: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && frame_cfg[5] && !frame_cfg[0]) |-> !rx_perr); // R5
  AST_SYNC_NO_ERRS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && frame_cfg[0]) |-> (!rx_perr && !rx_ferr)); // R11
endmodule

bind serframe_xcvr serframe_chk u_chk (
  .clk(clk), .rst(rst), .frame_cfg(frame_cfg), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .txd(txd), .sclk(sclk), .rx_valid(rx_valid),
  .rx_perr(rx_perr), .rx_ferr(rx_ferr)
);

// File: tb/serframe_xcvr_bench.sv
`timescale 1ns/1ps
module serframe_xcvr_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] frame_cfg = '0;
  logic       os_tick = 1'b1;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_mpb = 1'b0;
  logic       tx_ready, txd, sclk, rx_valid, rx_mpb, rx_perr, rx_ferr;
  logic [7:0] rx_data;
  logic       loop = 1'b1;
  logic       rx_line = 1'b1;
  logic       rxd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int         rx_cnt = 0;
  logic [7:0] last_data = '0, prev_data = '0;
  logic       last_mpb = 0, last_perr = 0, last_ferr = 0;

  always #2 clk = ~clk;
  assign rxd = loop ? txd : rx_line;

  serframe_xcvr u_serframe_xcvr (
    .clk(clk), .rst(rst), .frame_cfg(frame_cfg), .os_tick(os_tick),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_mpb(tx_mpb),
    .tx_ready(tx_ready), .txd(txd), .sclk(sclk), .rxd(rxd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      rx_cnt    = rx_cnt + 1;
      prev_data = last_data;
      last_data = rx_data;
      last_mpb  = rx_mpb;
      last_perr = rx_perr;
      last_ferr = rx_ferr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cfg: [0] sync [1] seven [2] par_en [3] odd [4] two_stop [5] mp
  function automatic void exp_frame(input logic [5:0] c, input logic [7:0] d,
                                    input logic m, output logic [11:0] b, output int n);
    int nd;
    logic [7:0] dm;
    b = '1;
    if (c[0]) begin
      b[7:0] = d;
      n = 8;
      return;
    end
    nd = c[1] ? 7 : 8;
    dm = c[1] ? (d & 8'h7f) : d;
    b[0] = 1'b0;
    for (int i = 0; i < nd; i++) b[1+i] = d[i];
    n = 1 + nd;
    if (c[5]) begin b[n] = m; n++; end
    else if (c[2]) begin b[n] = (^dm) ^ c[3]; n++; end
    n = n + 1 + int'(c[4]);
  endfunction

  task automatic send_async(input logic [5:0] c, input logic [7:0] d, input logic m);
    logic [11:0] b;
    int n, c0;
    string tag;
    exp_frame(c, d, m, b, n);
    loop = 1'b1;
    @(negedge clk);
    frame_cfg = c;
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_mpb = m; tx_valid = 1'b1;
    c0 = rx_cnt;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R6 ready low after accept", tx_ready, 0);
    for (int k = 0; k < n; k++) begin
      if (k == 0) repeat (8) @(posedge clk);
      else repeat (16) @(posedge clk);
      @(negedge clk);
      if (k == 0) tag = "R1 start";
      else if (k <= (c[1] ? 7 : 8)) tag = c[1] ? "R2 data" : "R1 data";
      else if (k == (c[1] ? 8 : 9) && (c[5] || c[2])) tag = c[5] ? "R5 mp bit" : "R3 parity";
      else tag = "R4 stop";
      chk(txd == b[k], tag, txd, b[k]);
    end
    chk(tx_ready == 1'b0, "R6 ready low in last bit", tx_ready, 0);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R6 ready back after frame", tx_ready, 1);
    chk(txd == 1'b1, "R1 idle high", txd, 1);
    chk(rx_cnt == c0 + 1, "R7 one char received", rx_cnt - c0, 1);
    chk(last_data == (c[1] ? (d & 8'h7f) : d), c[1] ? "R2 rx data" : "R7 rx data",
        last_data, c[1] ? (d & 8'h7f) : d);
    chk(last_perr == 1'b0, "R8 no parity error", last_perr, 0);
    chk(last_ferr == 1'b0, "R9 no framing error", last_ferr, 0);
    if (c[5]) chk(last_mpb == m, "R5 rx mp flag", last_mpb, m);
  endtask

  task automatic send_sync(input logic [5:0] c, input logic [7:0] d);
    int c0;
    loop = 1'b1;
    @(negedge clk);
    frame_cfg = c;
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    c0 = rx_cnt;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      repeat ((k == 0) ? 4 : 8) @(posedge clk);
      @(negedge clk);
      chk(sclk == 1'b0, "R10 sclk low first half", sclk, 0);
      chk(txd == d[k], "R10 sync data bit", txd, d[k]);
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk(sclk == 1'b1, "R10 sclk high second half", sclk, 1);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10 done after 8 bits", tx_ready, 1);
    chk(sclk == 1'b1, "R10 sclk idles high", sclk, 1);
    chk(rx_cnt == c0 + 1, "R11 one sync char", rx_cnt - c0, 1);
    chk(last_data == d, "R11 sync rx data", last_data, d);
    chk(!last_perr && !last_ferr, "R11 no error flags", {last_perr, last_ferr}, 0);
  endtask

  task automatic drive_rx(input logic [39:0] b, input int n);
    loop = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_line = b[k];
      repeat (15) @(negedge clk);
    end
    @(negedge clk);
    rx_line = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] fa, fb;
    int na, nb, c0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R6 reset ready", tx_ready, 1);
    chk(txd == 1'b1, "R1 reset line high", txd, 1);
    chk(sclk == 1'b1, "R10 reset sclk high", sclk, 1);
    chk(rx_valid == 1'b0, "R7 reset no valid", rx_valid, 0);

    send_async(6'b000000, 8'hA5, 1'b0);   // R1 8N1
    send_async(6'b000010, 8'hC3, 1'b0);   // R2 bit 7 dropped
    send_async(6'b000100, 8'h5B, 1'b0);   // R3 even
    send_async(6'b011100, 8'h5B, 1'b0);   // R3 odd, R4 two stops
    send_async(6'b101100, 8'h37, 1'b1);   // R5 parity settings ignored
    send_async(6'b100110, 8'hF0, 1'b0);   // R5 with 7-bit
    send_sync(6'b000011, 8'h96);          // R10 seven bit ignored
    send_sync(6'b111101, 8'h3C);          // R11

    // R8 parity error injection
    frame_cfg = 6'b000100;
    exp_frame(6'b000100, 8'h5A, 1'b0, fa, na);
    fa[9] = ~fa[9];
    c0 = rx_cnt;
    drive_rx({28'hfffffff, fa}, na);
    chk(rx_cnt == c0 + 1, "R8 char reported", rx_cnt - c0, 1);
    chk(last_perr == 1'b1, "R8 parity error flagged", last_perr, 1);

    // R9 framing error injection
    frame_cfg = 6'b000000;
    exp_frame(6'b000000, 8'h3C, 1'b0, fa, na);
    fa[9] = 1'b0;
    c0 = rx_cnt;
    drive_rx({28'hfffffff, fa}, na);
    chk(rx_cnt == c0 + 1, "R9 char reported", rx_cnt - c0, 1);
    chk(last_ferr == 1'b1, "R9 framing error flagged", last_ferr, 1);
    chk(last_data == 8'h3C, "R9 data kept", last_data, 8'h3C);

    // R9 second stop low begins next frame
    frame_cfg = 6'b010000;
    exp_frame(6'b000000, 8'h81, 1'b0, fa, na);
    exp_frame(6'b000000, 8'h4E, 1'b0, fb, nb);
    c0 = rx_cnt;
    drive_rx({20'hfffff, fb[9:0], fa[9:0]}, 20);
    chk(rx_cnt == c0 + 2, "R9 back to back count", rx_cnt - c0, 2);
    chk(prev_data == 8'h81, "R9 first char", prev_data, 8'h81);
    chk(last_data == 8'h4E, "R9 second char", last_data, 8'h4E);
    chk(last_ferr == 1'b0, "R9 no framing error", last_ferr, 0);

    // R12 short glitch ignored
    c0 = rx_cnt;
    loop = 1'b0;
    @(negedge clk); rx_line = 1'b0;
    repeat (4) @(negedge clk); rx_line = 1'b1;
    repeat (60) @(negedge clk);
    chk(rx_cnt == c0, "R12 glitch ignored", rx_cnt - c0, 0);

    // random async frames
    for (int i = 0; i < 24; i++) begin
      logic [5:0] c;
      c = 6'($urandom(32'd7 + 32'(i))) & 6'b111110;
      send_async(c, 8'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule